// File: doc/BRIEF.md
# Configurable Decade Counter with Split and Cascaded Sections

This block is a four-bit decade counter made of two sections that count on their own inputs. A modulo-2 section drives output bit 0. A modulo-5 section drives output bits 3..1 as a binary value from 0 to 4. Each section counts on a falling edge of its own count input. The whole block runs on one system clock, and each count input is sampled in that clock domain. A two-bit configuration input sets how the sections are joined:

- Split: the sections run independently.
- 8-4-2-1: the modulo-2 section feeds the modulo-5 section, giving a decimal count.
- Bi-quinary: the modulo-5 section feeds the modulo-2 section. Output bit 0 then becomes a square wave at one tenth of the input edge rate.

The joining is not done with derived clocks. Instead, an internal carry pulse is registered and used as a one-cycle count enable for the next section, which mimics a ripple carry.

An active-high clear forces all outputs low at once and may be driven from decoded outputs to build shorter count cycles. Two blocks can be chained for division by 100: feed output bit 3 of the first block, or output bit 0 in bi-quinary use, to a count input of the second.

Top module: `decade_cnt`

## Requirements
- R1: While `clr` is high, `q` is 0000 and `tc` is 0, whatever the count inputs do. The outputs go low without waiting for a clock edge.
- R2: In split mode (`mode`=00), each falling edge of `cnt_a_in` toggles `q[0]`.
- R3: In split mode, each falling edge of `cnt_b_in` advances `q[3:1]` through 0,1,2,3,4 in binary and then wraps to 0. `q[3:1]` never exceeds 4.
- R4: Only a high-to-low change of a count input advances a section. The section output changes on the second rising clock edge after the low level is first sampled. A rising input has no effect.
- R5: In 8-4-2-1 mode (`mode`=01), falling edges of `cnt_a_in` step `q` through 0000..1001, and the tenth edge returns it to 0000. `cnt_b_in` has no effect in this mode.
- R6: In bi-quinary mode (`mode`=10), falling edges of `cnt_b_in` step `q` as {q[3:1], q[0]} = (1,0),(2,0),(3,0),(4,0),(0,1),(1,1),(2,1),(3,1),(4,1), then back to 0000. `cnt_a_in` has no effect in this mode.
- R7: In modes 01 and 10, `tc` is high for exactly one clock cycle, in the cycle where `q` has just wrapped from its tenth state to 0000. In mode 00, `tc` stays low.
- R8: Changing `mode` leaves the present value of `q` unchanged.
- R9: On the first rising clock edge after `clr` falls, a pending count edge is discarded. Counting resumes on later edges.
- R10: Mode 11 behaves as split mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| clr | input | 1 | Asynchronous active-high count clear |
| cnt_a_in | input | 1 | Count input of the modulo-2 section |
| cnt_b_in | input | 1 | Count input of the modulo-5 section |
| mode | input | 2 | 00/11 split, 01 8-4-2-1 cascade, 10 bi-quinary cascade |
| q | output | 4 | Count value; bit 0 from the modulo-2 section, bits 3..1 from the modulo-5 section |
| tc | output | 1 | One-cycle wrap pulse in cascade modes |

## Verification
The assertions assume that `clr` and `mode` change away from rising clock edges. They also assume that each level of a count input lasts at least two system cycles, so that no falling edge is lost between samples. The stimulus changes every input on the falling clock edge and holds each count level for three or four cycles. That is long enough for a carry to ripple through both sections before the outputs are compared. The clear tests deliberately place a falling count edge so that it meets the release cycle.

// File: rtl/dcnt_pkg.sv
package dcnt_pkg;
  typedef enum logic [1:0] {
    CFG_SPLIT   = 2'b00,
    CFG_DEC     = 2'b01,
    CFG_BIQ     = 2'b10,
    CFG_SPLIT_B = 2'b11
  } cfg_e;

  localparam int unsigned LO_MOD = 2;
  localparam int unsigned HI_MOD = 5;
  localparam int unsigned LO_W   = $clog2(LO_MOD);
  localparam int unsigned HI_W   = $clog2(HI_MOD);
  localparam int unsigned OUT_W  = LO_W + HI_W;
endpackage

// File: rtl/dcnt_fall_det.sv
module dcnt_fall_det (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic fall
);
  logic smp_q, prv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q <= 1'b0;
      prv_q <= 1'b0;
    end else begin
      smp_q <= din;
      prv_q <= smp_q;
    end
  end

  assign fall = prv_q & ~smp_q;

  // R4: a detected fall follows a sample of 1 on the previous cycle
  a_r4_fall_after_high: assert property (@(posedge clk) disable iff (!rst_n)
    fall |-> $past(din, 2) && !$past(din, 1));
endmodule

// File: rtl/dcnt_modn.sv
module dcnt_modn #(
  parameter int unsigned MOD = 5,
  parameter int unsigned W   = $clog2(MOD)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  localparam logic [W-1:0] LAST = W'(MOD - 1);

  logic [W-1:0] cnt_nxt;

  always_comb begin
    if (cnt == LAST) cnt_nxt = '0;
    else             cnt_nxt = cnt + W'(1);
  end

  assign wrap = step && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n or posedge clr) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (step) cnt <= cnt_nxt;
  end

  a_r3_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
  a_r4_hold_without_step: assert property (@(posedge clk) disable iff (!rst_n || clr)
    !step |=> $stable(cnt));
endmodule

// File: rtl/decade_cnt.sv
module decade_cnt
  import dcnt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             cnt_a_in,
  input  logic             cnt_b_in,
  input  logic [1:0]       mode,
  output logic [OUT_W-1:0] q,
  output logic             tc
);
  cfg_e            cfg;
  logic            fall_a, fall_b;
  logic            hold_q;
  logic            step_lo, step_hi;
  logic            wrap_lo, wrap_hi;
  logic            lo_carry_q, hi_carry_q;
  logic            tc_nxt, tc_q;
  logic [LO_W-1:0] cnt_lo;
  logic [HI_W-1:0] cnt_hi;

  assign cfg = cfg_e'(mode);

  dcnt_fall_det u_det_a (.clk(clk), .rst_n(rst_n), .din(cnt_a_in), .fall(fall_a));
  dcnt_fall_det u_det_b (.clk(clk), .rst_n(rst_n), .din(cnt_b_in), .fall(fall_b));

  // clear release: hold for the first cycle after clr drops
  always_ff @(posedge clk or negedge rst_n or posedge clr) begin
    if (!rst_n)   hold_q <= 1'b1;
    else if (clr) hold_q <= 1'b1;
    else          hold_q <= 1'b0;
  end

  // section enables and wrap pulse
  always_comb begin
    step_lo = 1'b0;
    step_hi = 1'b0;
    tc_nxt  = 1'b0;
    if (!hold_q) begin
      unique case (cfg)
        CFG_DEC: begin
          step_lo = fall_a;
          step_hi = lo_carry_q;
          tc_nxt  = wrap_hi;
        end
        CFG_BIQ: begin
          step_lo = hi_carry_q;
          step_hi = fall_b;
          tc_nxt  = wrap_lo;
        end
        default: begin
          step_lo = fall_a;
          step_hi = fall_b;
        end
      endcase
    end
  end

  dcnt_modn #(.MOD(LO_MOD), .W(LO_W)) u_lo (
    .clk(clk), .rst_n(rst_n), .clr(clr), .step(step_lo), .cnt(cnt_lo), .wrap(wrap_lo));
  dcnt_modn #(.MOD(HI_MOD), .W(HI_W)) u_hi (
    .clk(clk), .rst_n(rst_n), .clr(clr), .step(step_hi), .cnt(cnt_hi), .wrap(wrap_hi));

  // carry pulses registered to model the ripple
  always_ff @(posedge clk or negedge rst_n or posedge clr) begin
    if (!rst_n) begin
      lo_carry_q <= 1'b0;
      hi_carry_q <= 1'b0;
      tc_q       <= 1'b0;
    end else if (clr) begin
      lo_carry_q <= 1'b0;
      hi_carry_q <= 1'b0;
      tc_q       <= 1'b0;
    end else begin
      lo_carry_q <= wrap_lo;
      hi_carry_q <= wrap_hi;
      tc_q       <= tc_nxt;
    end
  end

  assign q  = {cnt_hi, cnt_lo};
  assign tc = tc_q;

  a_r1_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> (q == '0) && !tc);
  a_r7_tc_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    tc |-> (q == '0));
  a_r7_tc_single: assert property (@(posedge clk) disable iff (!rst_n || clr)
    tc |=> !tc);
  a_r7_no_tc_split: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (mode == 2'b00) |=> !tc);
  a_r9_release_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(clr) && !clr) |-> (q == '0));
endmodule

// File: tb/test_decade_cnt.sv
module test_decade_cnt;
  logic       clk;
  logic       rst_n;
  logic       clr;
  logic       cnt_a_in;
  logic       cnt_b_in;
  logic [1:0] mode;
  logic [3:0] q;
  logic       tc;

  int checks = 0;
  int fails  = 0;
  int tc_seen = 0;
  int tc_bad  = 0;
  bit done = 0;

  decade_cnt i_decade_cnt (
    .clk(clk), .rst_n(rst_n), .clr(clr), .cnt_a_in(cnt_a_in),
    .cnt_b_in(cnt_b_in), .mode(mode), .q(q), .tc(tc));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {mode[1:0], pulse_a, pulse_b, expected q[3:0]}
  localparam int NV = 28;
  localparam logic [7:0] VEC [NV] = '{
    8'b01_10_0001, 8'b01_10_0010, 8'b01_10_0011, 8'b01_10_0100, 8'b01_10_0101,
    8'b01_01_0101,
    8'b01_10_0110, 8'b01_10_0111, 8'b01_10_1000, 8'b01_10_1001, 8'b01_10_0000,
    8'b10_01_0010, 8'b10_01_0100, 8'b10_01_0110,
    8'b10_10_0110,
    8'b10_01_1000, 8'b10_01_0001, 8'b10_01_0011, 8'b10_01_0101, 8'b10_01_0111,
    8'b10_01_1001, 8'b10_01_0000,
    8'b00_10_0001, 8'b00_01_0011, 8'b00_11_0100,
    8'b11_10_0101,
    8'b01_10_0110,
    8'b10_00_0110
  };

  always @(negedge clk) begin
    if (rst_n && tc) begin
      tc_seen++;
      if (q != 4'b0000) tc_bad++;
    end
  end

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] m, input logic pa, input logic pb);
    @(negedge clk);
    mode = m;
    cnt_a_in = pa;
    cnt_b_in = pb;
    repeat (3) @(negedge clk);
    cnt_a_in = 1'b0;
    cnt_b_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    rst_n = 1'b0; clr = 1'b0; cnt_a_in = 1'b0; cnt_b_in = 1'b0; mode = 2'b01;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 reset q", q, 4'b0000);
    check("R1 reset tc", {3'b000, tc}, 4'b0000);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] m;
      string tag;
      m = VEC[i][7:6];
      apply(m, VEC[i][5], VEC[i][4]);
      if (VEC[i][5:4] == 2'b00) tag = "R8";
      else if (m == 2'b01)      tag = "R5";
      else if (m == 2'b10)      tag = "R6";
      else if (m == 2'b11)      tag = "R10";
      else                      tag = "R2/R3";
      check($sformatf("%s vector %0d", tag, i), q, VEC[i][3:0]);
    end
    check("R7 tc pulse cycles", 4'(tc_seen), 4'd2);
    check("R7 tc with nonzero q", 4'(tc_bad), 4'd0);

    // R4: rising edge alone does nothing; the falling edge lands two edges later
    @(negedge clk);
    mode = 2'b00;
    cnt_a_in = 1'b1;
    repeat (4) @(negedge clk);
    check("R4 rising edge ignored", q, 4'b0110);
    cnt_a_in = 1'b0;
    @(negedge clk);
    check("R4 no change after one edge", q, 4'b0110);
    @(negedge clk);
    check("R4 advance on second edge", q, 4'b0111);
    repeat (3) @(negedge clk);

    // R1: asynchronous clear, count edges ignored while clear is high
    mode = 2'b01;
    clr = 1'b1;
    #1;
    check("R1 clear is immediate", q, 4'b0000);
    cnt_a_in = 1'b1;
    repeat (3) @(negedge clk);
    cnt_a_in = 1'b0;
    repeat (4) @(negedge clk);
    check("R1 edges blocked during clear", q, 4'b0000);
    check("R1 tc low during clear", {3'b000, tc}, 4'b0000);

    // R9: an edge detected at the release edge is dropped
    cnt_a_in = 1'b1;
    repeat (3) @(negedge clk);
    cnt_a_in = 1'b0;
    @(negedge clk);
    clr = 1'b0;
    repeat (4) @(negedge clk);
    check("R9 release edge dropped", q, 4'b0000);
    apply(2'b01, 1'b1, 1'b0);
    check("R9 count resumes", q, 4'b0001);
    check("R7 no extra tc", 4'(tc_seen), 4'd2);

    done = 1;
    summary();
  end
endmodule